// File: doc/BRIEF.md
# LFSR Program Sequencer with Return Stack

This block produces the instruction fetch address for a small stack processor. Instead of adding one to the program counter, it steps the counter through a maximal-length linear feedback shift register sequence. The program still visits memory in a fixed order, and the shift-and-XNOR step is much shallower logic than a carry chain. Code is laid out in memory in that same order.

The decode stage drives four controls: a jump flag, a call flag, a return flag and a target address. A jump or a call loads the target in a single cycle. A call also writes its own sequential successor into a dedicated return-address stack. A return is flagged on an ordinary instruction and costs no extra cycle, because the next fetch address is read straight from the top of that stack.

The stack wraps in a circle when it overflows or underflows. Neither case stalls the block; each one sets a sticky error flag instead.

Top module: `lfsr_pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next `fetch_pc` is 0, both error flags are 0 and the stack becomes empty. The stack storage itself is not cleared.
- R2: With no control asserted, the next `fetch_pc` is `{pc[8:0], ~(pc[9] ^ pc[6])}`, where pc is the current `fetch_pc`.
- R3: Starting from 0, sequential stepping visits 1023 distinct addresses, returns to 0 after exactly 1023 steps and never produces 0x3FF.
- R4: `br_jump` alone makes the next `fetch_pc` equal `br_target`.
- R5: `br_call` makes the next `fetch_pc` equal `br_target` and pushes the R2 successor of the current `fetch_pc` onto the return stack.
- R6: `br_ret` makes the very next `fetch_pc` equal the top of the return stack and pops it. Nested calls return in last-in, first-out order.
- R7: Priority is `rst`, then `br_ret`, then `br_call`, then `br_jump`, then sequential. With `br_ret` and `br_call` both high, nothing is pushed. With `br_call` and `br_jump` both high, the push still happens.
- R8: A push while the stack holds 16 entries sets `rs_ovf_err`, which stays set until reset. The oldest entry is overwritten, execution continues, and the 16 newest entries return correctly.
- R9: A pop while the stack is empty sets `rs_unf_err`, which stays set until reset. The pointer still moves back one slot, and the next address is whatever that slot holds.
- R10: `rst` overrides any control asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_jump | input | 1 | Load target |
| br_call | input | 1 | Load target and push return address |
| br_ret | input | 1 | Next address from top of return stack |
| br_target | input | 10 | Jump or call destination |
| fetch_pc | output | 10 | Registered fetch address |
| rs_ovf_err | output | 1 | Sticky return-stack overflow flag |
| rs_unf_err | output | 1 | Sticky return-stack underflow flag |

## Verification
A full run of 1023 idle cycles from reset exercises the shift step. It tells a correct feedback polynomial and tap set from a wrong one by the period length and by whether 0x3FF ever appears. Chains of jumps, calls nested three deep, and back-to-back call-then-return separate the target path from the stack path and test last-in, first-out order. Cycles with several controls raised together, including one with reset, check that the priority order is right and that no push is lost or added. Seventeen nested calls followed by seventeen returns, and a return on an empty stack after reset, show the wrap behaviour, that the flags stay set, and that the sequencer never stalls.

// File: rtl/lfsr_seq_pkg.sv
package lfsr_seq_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_JMP  = 2'd1,
    SRC_CALL = 2'd2,
    SRC_RET  = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int W       = 10,
  parameter int TAP_A   = 10,
  parameter int TAP_B   = 7,
  parameter bit XNOR_FB = 1'b1
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb_raw;
  logic fb;

  assign fb_raw = cur[TAP_A-1] ^ cur[TAP_B-1];

  generate
    if (XNOR_FB) begin : g_xnor
      assign fb = ~fb_raw;
    end else begin : g_xor
      assign fb = fb_raw;
    end
  endgenerate

  assign nxt = {cur[W-2:0], fb};
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] tos,
  output logic          ovf_err,
  output logic          unf_err
);
  localparam int SP_W  = $clog2(DEPTH);
  localparam int OCC_W = SP_W + 1;

  logic [AW-1:0]    mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  rd_idx;
  logic [OCC_W-1:0] occ;
  logic             full;
  logic             empty;

  assign rd_idx = sp - SP_W'(1);
  assign tos    = mem[rd_idx];
  assign full   = (occ == OCC_W'(DEPTH));
  assign empty  = (occ == '0);

  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp      <= '0;
      occ     <= '0;
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else if (push) begin
      sp <= sp + SP_W'(1);
      if (full) ovf_err <= 1'b1;
      else      occ     <= occ + OCC_W'(1);
    end else if (pop) begin
      sp <= rd_idx;
      if (empty) unf_err <= 1'b1;
      else       occ     <= occ - OCC_W'(1);
    end
  end

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    unf_err |=> unf_err);
  assert_push_visible_R5: assert property (@(posedge clk) disable iff (rst)
    push |=> tos == $past(push_data));
  assert_pop_count_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> occ == $past(occ) - OCC_W'(1));
  assert_ovf_on_full_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf_err);
endmodule

// File: rtl/next_sel.sv
module next_sel
  import lfsr_seq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          do_ret,
  input  logic          do_call,
  input  logic          do_jump,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] tos,
  input  logic [AW-1:0] seq_next,
  output logic [AW-1:0] next_pc,
  output logic          push,
  output logic          pop
);
  nxt_src_e src;

  always_comb begin
    if      (do_ret)  src = SRC_RET;
    else if (do_call) src = SRC_CALL;
    else if (do_jump) src = SRC_JMP;
    else              src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_RET:          next_pc = tos;
      SRC_CALL, SRC_JMP: next_pc = target;
      default:          next_pc = seq_next;
    endcase
  end

  assign push = (src == SRC_CALL);
  assign pop  = (src == SRC_RET);
endmodule

// File: rtl/lfsr_pc_seq.sv
module lfsr_pc_seq #(
  parameter int PC_W     = 10,
  parameter int TAP_A    = 10,
  parameter int TAP_B    = 7,
  parameter int RS_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            br_jump,
  input  logic            br_call,
  input  logic            br_ret,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] fetch_pc,
  output logic            rs_ovf_err,
  output logic            rs_unf_err
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_next;
  logic [PC_W-1:0] next_pc;
  logic [PC_W-1:0] tos;
  logic            sel_push;
  logic            sel_pop;
  logic            rs_push;
  logic            rs_pop;

  lfsr_step #(.W(PC_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .XNOR_FB(1'b1)) u_step (
    .cur (pc_q),
    .nxt (seq_next)
  );

  next_sel #(.AW(PC_W)) u_sel (
    .do_ret   (br_ret),
    .do_call  (br_call),
    .do_jump  (br_jump),
    .target   (br_target),
    .tos      (tos),
    .seq_next (seq_next),
    .next_pc  (next_pc),
    .push     (sel_push),
    .pop      (sel_pop)
  );

  assign rs_push = sel_push & ~rst;
  assign rs_pop  = sel_pop  & ~rst;

  ret_stack #(.AW(PC_W), .DEPTH(RS_DEPTH)) u_rs (
    .clk       (clk),
    .rst       (rst),
    .push      (rs_push),
    .pop       (rs_pop),
    .push_data (seq_next),
    .tos       (tos),
    .ovf_err   (rs_ovf_err),
    .unf_err   (rs_unf_err)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  assign fetch_pc = pc_q;

  // R1 and R10: reset wins over every control
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (fetch_pc == '0) && !rs_ovf_err && !rs_unf_err);
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!br_ret && !br_call && !br_jump) |=> fetch_pc == $past(seq_next));
  assert_no_lockup_R3: assert property (@(posedge clk) disable iff (rst)
    (!br_ret && !br_call && !br_jump && fetch_pc != '1) |=> fetch_pc != '1);
  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (br_jump && !br_call && !br_ret) |=> fetch_pc == $past(br_target));
  assert_call_R5: assert property (@(posedge clk) disable iff (rst)
    (br_call && !br_ret) |=> fetch_pc == $past(br_target));
  assert_ret_R6: assert property (@(posedge clk) disable iff (rst)
    br_ret |=> fetch_pc == $past(tos));
  assert_ret_over_call_R7: assert property (@(posedge clk) disable iff (rst)
    (br_ret && br_call) |=> fetch_pc == $past(tos));
endmodule

// File: tb/sim_lfsr_pc_seq.sv
`timescale 1ns/1ps
module sim_lfsr_pc_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       br_jump = 1'b0, br_call = 1'b0, br_ret = 1'b0;
  logic [9:0] br_target = '0;
  logic [9:0] fetch_pc;
  logic       rs_ovf_err, rs_unf_err;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lfsr_pc_seq u0 (
    .clk(clk), .rst(rst), .br_jump(br_jump), .br_call(br_call),
    .br_ret(br_ret), .br_target(br_target), .fetch_pc(fetch_pc),
    .rs_ovf_err(rs_ovf_err), .rs_unf_err(rs_unf_err)
  );

  typedef struct { logic [9:0] exp; string tag; } item_t;
  item_t q[$];

  // bench model, built from the requirements
  logic [9:0] mpc = '0;
  logic [9:0] marr [16];
  logic [3:0] msp = '0;
  int         mocc = 0;
  bit         mo = 0, mu = 0;
  bit         seen [1024];
  bit         recording = 0;

  function automatic logic [9:0] succ(input logic [9:0] x);
    return {x[8:0], ~(x[9] ^ x[6])};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit j, input bit c, input bit rt,
                      input logic [9:0] t, input string tag);
    item_t it;
    logic [9:0] e;
    @(negedge clk);
    rst = r; br_jump = j; br_call = c; br_ret = rt; br_target = t;
    if (r) begin
      e = '0; msp = '0; mocc = 0; mo = 0; mu = 0;
    end else if (rt) begin
      e = marr[msp - 4'd1];
      if (mocc == 0) mu = 1; else mocc--;
      msp = msp - 4'd1;
    end else if (c) begin
      e = t;
      marr[msp] = succ(mpc);
      msp = msp + 4'd1;
      if (mocc == 16) mo = 1; else mocc++;
    end else if (j) begin
      e = t;
    end else begin
      e = succ(mpc);
    end
    mpc = e;
    it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, '0, tag);
  endtask

  task automatic chk_flags(input string tag);
    @(posedge clk);
    #3;
    check(rs_ovf_err == mo, {tag, " ovf"}, rs_ovf_err, mo);
    check(rs_unf_err == mu, {tag, " unf"}, rs_unf_err, mu);
  endtask

  // monitor: compares each registered fetch address with the queued expectation
  always @(posedge clk) begin
    item_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      if (recording) seen[fetch_pc] = 1'b1;
      check(fetch_pc === it.exp, it.tag, fetch_pc, it.exp);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < 16; i++) marr[i] = '0;
    for (int i = 0; i < 1024; i++) seen[i] = 1'b0;

    // R1 reset state
    repeat (2) @(posedge clk);
    step(1, 0, 0, 0, '0, "R1");
    chk_flags("R1");

    // R2 / R3 full sequential period
    recording = 1;
    for (int i = 0; i < 1023; i++) idle(i == 1022 ? "R3" : "R2");
    chk_flags("R2");
    recording = 0;
    cnt = 0;
    for (int i = 0; i < 1024; i++) cnt += seen[i];
    check(cnt == 1023, "R3 distinct", cnt, 1023);
    check(!seen[1023], "R3 no 0x3FF", seen[1023], 0);

    // R4 jumps
    step(0, 1, 0, 0, 10'h155, "R4");
    idle("R2"); idle("R2");
    step(0, 1, 0, 0, 10'h3A0, "R4");
    idle("R2");

    // R5 / R6 nested calls and zero-cycle returns
    step(0, 0, 1, 0, 10'h200, "R5");
    idle("R2");
    step(0, 0, 1, 0, 10'h0AA, "R5");
    step(0, 0, 1, 0, 10'h013, "R5");
    idle("R2");
    step(0, 0, 0, 1, '0, "R6");
    step(0, 0, 0, 1, '0, "R6");
    idle("R2");
    step(0, 0, 0, 1, '0, "R6");
    step(0, 0, 1, 0, 10'h077, "R5");
    step(0, 0, 0, 1, '0, "R6");
    idle("R2");

    // R7 priority
    step(0, 0, 1, 0, 10'h111, "R7");
    step(0, 1, 1, 1, 10'h222, "R7");
    idle("R2");
    step(0, 1, 1, 0, 10'h0F0, "R7");
    step(0, 0, 0, 1, '0, "R7");
    chk_flags("R7");

    // R10 reset beats controls
    step(0, 0, 1, 0, 10'h123, "R5");
    step(1, 1, 1, 0, 10'h321, "R10");
    chk_flags("R10");
    step(1, 0, 0, 1, '0, "R10");

    // R8 overflow: 17 pushes, 16 good pops
    for (int i = 0; i < 17; i++) step(0, 0, 1, 0, 10'((i * 37 + 5) & 10'h1FF), "R8");
    chk_flags("R8");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, '0, "R8");
    chk_flags("R8");

    // R9 underflow after the stack drains
    step(0, 0, 0, 1, '0, "R9");
    chk_flags("R9");

    // R1 clears flags; R9 pop on empty after reset
    step(1, 0, 0, 0, '0, "R1");
    chk_flags("R1");
    step(0, 0, 0, 1, '0, "R9");
    chk_flags("R9");
    idle("R9"); idle("R9");
    step(0, 1, 0, 0, 10'h0C3, "R4");
    chk_flags("R9");

    @(negedge clk);
    br_jump = 0; br_call = 0; br_ret = 0;
    @(posedge clk);
    #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule